// File: doc/BRIEF.md
# Byte-Budget Round-Robin Arbiter for a Shared Data Mover

Several DMA channels share a single data mover, and only one of them may drive it at a time. This arbiter decides which channel that is. A channel holds its request line high for as long as it has work queued. Once granted, the channel keeps the mover until it has moved a programmable number of bytes, called its quantum. Each channel has its own quantum register. The mover reports every transfer beat together with its size in bytes, and the arbiter adds these up.

When the quantum is used up and another channel is waiting, the grant passes to the next waiting channel in rotating order. When no other channel is waiting, the owner keeps the grant without any gap and starts a new budget. When the owner lowers its request early, the arbiter hands the mover on at once, or goes idle if nobody else is waiting. A one-cycle strobe marks every change of the grant output, so the mover can reload its context.

Top module: `dma_quantum_arb`

## Requirements
- R1: After reset the grant output is all-zero, the change strobe is low, and every channel's quantum register holds 1024 bytes.
- R2: The grant output is one-hot or all-zero, and a set grant bit always belongs to a channel whose request was high at the edge that produced it.
- R3: With no grant active and at least one request high, the next cycle grants the first requesting channel, searching from the channel after the one granted last and wrapping from channel 3 to channel 0. After reset the search starts at channel 0.
- R4: Only cycles with beat_valid high while the granted channel requests add beat_bytes (0 to 64) to the byte count. The quantum expires on the beat that brings the count to or above the quantum. Bytes beyond the quantum are discarded, not carried over.
- R5: On expiry with another channel requesting, the grant moves on the next cycle to the next requester in rotating order after the current owner.
- R6: On expiry with no other channel requesting, the owner keeps the grant with no idle cycle and no strobe, its count restarts at zero, and its quantum is re-sampled.
- R7: If the owner's request is low at an edge, the grant moves at that edge to the next requester in rotating order, or to all-zero when there is none. The beat in that cycle is not counted.
- R8: The quantum is captured whenever a grant is given or renewed. A register write during a grant affects only later grants.
- R9: A quantum of zero expires on the first valid beat, whatever its size.
- R10: grant_chg is high for exactly the cycles whose grant value differs from the previous cycle's, including a change to all-zero.
- R11: At an edge where q_load bit i is high, channel i's quantum register takes bits [16*i+15:16*i] of q_value. The new value is first usable by a grant given at a later edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ch_req | input | 4 | Per-channel request, bit i = channel i |
| q_load | input | 4 | Per-channel quantum register write enable |
| q_value | input | 64 | Quantum write data, 16 bits per channel, channel i at [16*i+15:16*i] |
| beat_valid | input | 1 | Mover moved a beat this cycle |
| beat_bytes | input | 7 | Bytes moved in this beat, 0 to 64 |
| grant | output | 4 | One-hot grant, all-zero when idle |
| grant_chg | output | 1 | One-cycle strobe on any grant change |

## Verification
The bench targets the counting edge cases. Excess bytes at expiry must be dropped, so a design that carried them over would hand the mover on one beat early. A quantum written mid-grant must take effect only on the next grant, so a design that read the register live would cut the current owner short. The bench also covers a lone requester at expiry, where a wrong design would insert an idle cycle or raise a spurious strobe. It covers wrap-around of the rotating search and a zero quantum, where a wrong design would never expire or would expire without a beat. A long random phase then compares every cycle against a model built from the requirements.

// File: rtl/dqa_pkg.sv
package dqa_pkg;
   // Outcome of one arbitration cycle
   typedef enum logic [1:0] {
      DEC_HOLD    = 2'd0,  // keep owner, keep counting
      DEC_GRANT   = 2'd1,  // give the mover to a (new) channel
      DEC_RENEW   = 2'd2,  // owner keeps mover, fresh budget
      DEC_RELEASE = 2'd3   // nobody left, go idle
   } arb_dec_e;

   localparam int unsigned DQA_RESET_QUANTUM = 1024;
endpackage

// File: rtl/dqa_rr_pick.sv
module dqa_rr_pick #(
   parameter int unsigned N  = 4,
   parameter int unsigned IW = 2
) (
   input  logic [N-1:0]  req,
   input  logic [IW-1:0] start,
   input  logic          excl_en,
   input  logic [IW-1:0] excl_idx,
   output logic          found,
   output logic [IW-1:0] idx
);
   localparam bit POW2 = ((1 << IW) == N);

   generate
      if (POW2) begin : g_mask_wrap
         always_comb begin
            found = 1'b0;
            idx   = '0;
            for (int k = 0; k < N; k++) begin
               logic [IW-1:0] pos;
               pos = start + IW'(k);
               if (!found && req[pos] && !(excl_en && (excl_idx == pos))) begin
                  found = 1'b1;
                  idx   = pos;
               end
            end
         end
      end else begin : g_sub_wrap
         always_comb begin
            found = 1'b0;
            idx   = '0;
            for (int k = 0; k < N; k++) begin
               int pos;
               pos = int'(start) + k;
               if (pos >= int'(N)) pos = pos - int'(N);
               if (!found && req[IW'(pos)] && !(excl_en && (excl_idx == IW'(pos)))) begin
                  found = 1'b1;
                  idx   = IW'(pos);
               end
            end
         end
      end
   endgenerate
endmodule

// File: rtl/dqa_quantum_bank.sv
module dqa_quantum_bank #(
   parameter int unsigned N       = 4,
   parameter int unsigned QW      = 16,
   parameter int unsigned INIT_Q  = 1024
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  load,
   input  logic [N*QW-1:0] wdata,
   output logic [N*QW-1:0] quanta
);
   generate
      for (genvar i = 0; i < N; i++) begin : g_lane
         logic [QW-1:0] q_r;
         always_ff @(posedge clk) begin
            if (!rst_n)       q_r <= QW'(INIT_Q);
            else if (load[i]) q_r <= wdata[i*QW +: QW];
         end
         assign quanta[i*QW +: QW] = q_r;
      end
   endgenerate
endmodule

// File: rtl/dqa_byte_meter.sv
module dqa_byte_meter #(
   parameter int unsigned QW = 16,
   parameter int unsigned BW = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          restart,
   input  logic [QW-1:0] new_quota,
   input  logic          beat_en,
   input  logic [BW-1:0] beat_bytes,
   output logic          expire
);
   logic [QW:0]   cnt_q;
   logic [QW-1:0] quota_q;
   logic [QW:0]   sum;

   assign sum    = cnt_q + {{(QW+1-BW){1'b0}}, beat_bytes};
   assign expire = beat_en && ((quota_q == '0) || (sum >= {1'b0, quota_q}));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         quota_q <= QW'(1);
      end else if (restart) begin
         cnt_q   <= '0;
         quota_q <= new_quota;
      end else if (beat_en) begin
         cnt_q   <= sum;
      end
   end
endmodule

// File: rtl/dma_quantum_arb.sv
module dma_quantum_arb
   import dqa_pkg::*;
#(
   parameter int unsigned NUM_CH          = 4,
   parameter int unsigned QUANT_W         = 16,
   parameter int unsigned MAX_BEAT        = 64,
   parameter int unsigned DEFAULT_QUANTUM = DQA_RESET_QUANTUM
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NUM_CH-1:0]           ch_req,
   input  logic [NUM_CH-1:0]           q_load,
   input  logic [NUM_CH*QUANT_W-1:0]   q_value,
   input  logic                        beat_valid,
   input  logic [$clog2(MAX_BEAT+1)-1:0] beat_bytes,
   output logic [NUM_CH-1:0]           grant,
   output logic                        grant_chg
);
   localparam int unsigned IDX_W  = $clog2(NUM_CH);
   localparam int unsigned BEAT_W = $clog2(MAX_BEAT+1);

   generate
      if (NUM_CH < 2) begin : g_bad_ch
         $error("dma_quantum_arb: NUM_CH must be at least 2");
      end
      if (MAX_BEAT < 1) begin : g_bad_beat
         $error("dma_quantum_arb: MAX_BEAT must be at least 1");
      end
      if (QUANT_W < BEAT_W) begin : g_bad_qw
         $error("dma_quantum_arb: QUANT_W narrower than a beat count");
      end
      if (DEFAULT_QUANTUM >= (64'd1 << QUANT_W)) begin : g_bad_def
         $error("dma_quantum_arb: DEFAULT_QUANTUM does not fit QUANT_W");
      end
   endgenerate

   logic                      active_q;
   logic [IDX_W-1:0]          cur_q;
   logic [IDX_W-1:0]          last_q;
   logic [NUM_CH-1:0]         grant_q;
   logic                      chg_q;

   logic [NUM_CH*QUANT_W-1:0] quanta;
   logic [IDX_W-1:0]          search_start;
   logic                      pick_found;
   logic [IDX_W-1:0]          pick_idx;
   logic                      owner_req;
   logic                      beat_en;
   logic                      expire;
   arb_dec_e                  dec;
   logic [IDX_W-1:0]          nxt_idx;
   logic [QUANT_W-1:0]        nxt_quota;

   dqa_quantum_bank #(
      .N      (NUM_CH),
      .QW     (QUANT_W),
      .INIT_Q (DEFAULT_QUANTUM)
   ) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (q_load),
      .wdata  (q_value),
      .quanta (quanta)
   );

   assign search_start = (last_q == IDX_W'(NUM_CH-1)) ? '0 : last_q + 1'b1;

   dqa_rr_pick #(
      .N  (NUM_CH),
      .IW (IDX_W)
   ) u_pick (
      .req      (ch_req),
      .start    (search_start),
      .excl_en  (active_q),
      .excl_idx (cur_q),
      .found    (pick_found),
      .idx      (pick_idx)
   );

   assign owner_req = ch_req[cur_q];
   assign beat_en   = active_q && owner_req && beat_valid;

   always_comb begin
      dec     = DEC_HOLD;
      nxt_idx = cur_q;
      if (!active_q) begin
         if (pick_found) begin
            dec     = DEC_GRANT;
            nxt_idx = pick_idx;
         end
      end else if (!owner_req) begin
         if (pick_found) begin
            dec     = DEC_GRANT;
            nxt_idx = pick_idx;
         end else begin
            dec     = DEC_RELEASE;
         end
      end else if (expire) begin
         if (pick_found) begin
            dec     = DEC_GRANT;
            nxt_idx = pick_idx;
         end else begin
            dec     = DEC_RENEW;
         end
      end
   end

   assign nxt_quota = quanta[nxt_idx*QUANT_W +: QUANT_W];

   dqa_byte_meter #(
      .QW (QUANT_W),
      .BW (BEAT_W)
   ) u_meter (
      .clk        (clk),
      .rst_n      (rst_n),
      .restart    (dec != DEC_HOLD),
      .new_quota  (nxt_quota),
      .beat_en    (beat_en),
      .beat_bytes (beat_bytes),
      .expire     (expire)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         cur_q    <= IDX_W'(NUM_CH-1);
         last_q   <= IDX_W'(NUM_CH-1);
         grant_q  <= '0;
         chg_q    <= 1'b0;
      end else begin
         unique case (dec)
            DEC_GRANT: begin
               active_q <= 1'b1;
               cur_q    <= nxt_idx;
               last_q   <= nxt_idx;
               grant_q  <= NUM_CH'(1) << nxt_idx;
               chg_q    <= 1'b1;
            end
            DEC_RELEASE: begin
               active_q <= 1'b0;
               grant_q  <= '0;
               chg_q    <= 1'b1;
            end
            default: begin
               chg_q    <= 1'b0;
            end
         endcase
      end
   end

   assign grant     = grant_q;
   assign grant_chg = chg_q;
endmodule

// File: rtl/dqa_checker.sv
module dqa_checker #(
   parameter int unsigned NUM_CH = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic [NUM_CH-1:0] ch_req,
   input logic [NUM_CH-1:0] grant,
   input logic              grant_chg,
   input logic              beat_valid
);
   // R2: never more than one owner
   a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));

   // R2: an owner was requesting at the edge that chose it
   a_r2_owner_requested: assert property (@(posedge clk) disable iff (!rst_n)
      (grant != '0) |=> ((grant & $past(ch_req)) == grant));

   // R10: strobe marks exactly the cycles where the grant moved
   a_r10_strobe_on_change: assert property (@(posedge clk) disable iff (!rst_n)
      (grant != $past(grant)) |-> grant_chg);
   a_r10_strobe_only_on_change: assert property (@(posedge clk) disable iff (!rst_n)
      grant_chg |-> (grant != $past(grant)));

   // R3: an idle arbiter facing a request grants on the next cycle
   a_r3_no_idle_with_request: assert property (@(posedge clk) disable iff (!rst_n)
      ((ch_req != '0) && (grant == '0)) |=> (grant != '0));

   // R4: without a beat the requesting owner cannot lose the mover
   a_r4_hold_without_beat: assert property (@(posedge clk) disable iff (!rst_n)
      (((grant & ch_req) != '0) && !beat_valid) |=> $stable(grant));
endmodule

bind dma_quantum_arb dqa_checker #(.NUM_CH(NUM_CH)) u_dqa_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ch_req     (ch_req),
   .grant      (grant),
   .grant_chg  (grant_chg),
   .beat_valid (beat_valid)
);

// File: tb/tb_dma_quantum_arb.sv
`timescale 1ns/1ps
module tb_dma_quantum_arb;
   localparam int NCH = 4;
   localparam int QW  = 16;

   logic            clk = 1'b0;
   logic            rst_n;
   logic [NCH-1:0]  ch_req;
   logic [NCH-1:0]  q_load;
   logic [NCH*QW-1:0] q_value;
   logic            beat_valid;
   logic [6:0]      beat_bytes;
   logic [NCH-1:0]  grant;
   logic            grant_chg;

   always #4 clk = ~clk;  // 125 MHz

   dma_quantum_arb dut (
      .clk(clk), .rst_n(rst_n), .ch_req(ch_req), .q_load(q_load),
      .q_value(q_value), .beat_valid(beat_valid), .beat_bytes(beat_bytes),
      .grant(grant), .grant_chg(grant_chg)
   );

   typedef struct {
      logic [NCH-1:0] g;
      logic           c;
      string          tag;
   } exp_t;

   exp_t sb_q[$];
   int   checks = 0;
   int   failures = 0;
   bit   done = 0;

   // requirement model state
   bit m_active = 0;
   int m_cur = NCH-1, m_last = NCH-1, m_cnt = 0, m_quota = 1;
   int m_q[NCH];
   logic [NCH-1:0] m_grant = '0;

   function automatic int pick(logic [NCH-1:0] rq, int start, bit ex_en, int ex);
      for (int k = 0; k < NCH; k++) begin
         int p;
         p = (start + k) % NCH;
         if (rq[p] && !(ex_en && p == ex)) return p;
      end
      return -1;
   endfunction

   task automatic model_grant(int p);
      m_active = 1; m_cur = p; m_last = p; m_cnt = 0; m_quota = m_q[p];
      m_grant = NCH'(1) << p;
   endtask

   task automatic step(input logic [NCH-1:0] rq, input bit bv, input int by,
                       input logic [NCH-1:0] ld, input int ldval, input string tag);
      exp_t e;
      logic [NCH-1:0] old_g;
      int p, sum;
      @(negedge clk);
      ch_req = rq; beat_valid = bv; beat_bytes = 7'(by);
      q_load = ld; q_value = {NCH{QW'(ldval)}};
      old_g = m_grant;
      p = pick(rq, (m_last + 1) % NCH, m_active, m_cur);
      if (!m_active) begin
         if (p >= 0) model_grant(p);
      end else if (!rq[m_cur]) begin
         if (p >= 0) model_grant(p);
         else begin m_active = 0; m_grant = '0; end
      end else if (bv) begin
         sum = m_cnt + by;
         if (m_quota == 0 || sum >= m_quota) begin
            if (p >= 0) model_grant(p);
            else begin m_cnt = 0; m_quota = m_q[m_cur]; end
         end else m_cnt = sum;
      end
      for (int i = 0; i < NCH; i++) if (ld[i]) m_q[i] = ldval;
      e.g = m_grant; e.c = (m_grant != old_g); e.tag = tag;
      @(posedge clk);
      sb_q.push_back(e);
   endtask

   // monitor: compare one expected item per cycle, away from the edge
   always @(negedge clk) begin
      if (sb_q.size() > 0) begin
         exp_t e;
         e = sb_q.pop_front();
         checks++;
         if (grant !== e.g || grant_chg !== e.c) begin
            failures++;
            $display("FAIL %s grant=%b chg=%b expected grant=%b chg=%b",
                     e.tag, grant, grant_chg, e.g, e.c);
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < NCH; i++) m_q[i] = 1024;
      rst_n = 0; ch_req = '0; q_load = '0; q_value = '0;
      beat_valid = 0; beat_bytes = '0;
      repeat (4) @(posedge clk);
      @(negedge clk); rst_n = 1;
      // R1: reset state
      checks++;
      if (grant !== '0 || grant_chg !== 1'b0) begin
         failures++;
         $display("FAIL R1 grant=%b chg=%b expected grant=0000 chg=0", grant, grant_chg);
      end

      // R3: first grant from channel 0 side
      step(4'b0001, 0, 0, '0, 0, "R3");
      // R1: default 1024-byte quantum, 15 beats hold, 16th hands over
      for (int i = 0; i < 15; i++) step(4'b0011, 1, 64, '0, 0, "R1");
      step(4'b0011, 1, 64, '0, 0, "R5");
      // R11: write 10 to every lane; R8: current owner keeps 1024
      step(4'b0011, 0, 0, 4'b1111, 10, "R11");
      for (int i = 0; i < 15; i++) step(4'b0011, 1, 64, '0, 0, "R8");
      step(4'b0011, 1, 64, '0, 0, "R8");          // wraps to channel 0
      // R6: lone requester renews without strobe
      step(4'b0001, 1, 4, '0, 0, "R6");
      step(4'b0001, 1, 4, '0, 0, "R6");
      step(4'b0001, 1, 4, '0, 0, "R6");
      // R4: excess bytes dropped; count restarts at 0
      step(4'b0101, 1, 4, '0, 0, "R4");
      step(4'b0101, 1, 4, '0, 0, "R4");
      step(4'b0101, 1, 4, '0, 0, "R4");          // reaches 12, moves to ch2
      // R4: invalid beats do not count
      for (int i = 0; i < 4; i++) step(4'b0100, 0, 64, '0, 0, "R4");
      // R7: owner drops, next requester takes over, then idle
      step(4'b1000, 1, 64, '0, 0, "R7");
      step(4'b0000, 0, 0, '0, 0, "R7");
      step(4'b0000, 0, 0, '0, 0, "R10");
      // R3: search after channel 3 wraps to channel 0
      step(4'b0101, 0, 0, '0, 0, "R3");
      step(4'b1111, 1, 10, '0, 0, "R5");
      // R9: zero quantum on channel 1
      step(4'b1111, 0, 0, 4'b0010, 0, "R11");
      step(4'b1111, 1, 10, '0, 0, "R5");
      step(4'b1111, 1, 10, '0, 0, "R5");
      step(4'b1111, 1, 10, '0, 0, "R5");
      step(4'b1111, 1, 10, '0, 0, "R9");          // channel 1 now owner
      step(4'b1111, 1, 1, '0, 0, "R9");           // one byte expires it
      // mixed random traffic against the model
      for (int n = 0; n < 600; n++) begin
         logic [NCH-1:0] rq, ld;
         rq = NCH'($urandom_range(0, 15));
         ld = ($urandom_range(0, 9) == 0) ? NCH'($urandom_range(1, 15)) : '0;
         step(rq, $urandom_range(0, 3) != 0, $urandom_range(0, 64), ld,
              $urandom_range(0, 160), "R2");
      end
      @(negedge clk);
      @(negedge clk);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule